// File: doc/BRIEF.md
# DMA Channel Event Status and Pause Control

This block holds the per-channel control and status state of a multi-channel DMA engine. For each channel it keeps an interrupt control word, a channel enable flag, and a pause request with its acknowledge. The transfer engine, which is outside this block, reports five kinds of event as single-cycle pulses: fragment done, block done, transaction done, list done and configuration error. Each pulse sets a sticky status flag, but only when software has enabled that event. Software clears flags by writing ones to a separate clear field. Any enabled flag that is set raises the channel's interrupt line. A global read-only word gathers one interrupt bit per channel.

A pause request goes straight to the engine. The acknowledge rises only after the engine reports through its idle input that it has stopped at a transfer boundary. Software reaches all of the state through a simple register port. A write is a one-cycle strobe that takes effect at the clock edge, and read data is combinational from the address. No pin carries a data stream, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status level.

The register address is {global, channel, select}. The top bit picks the global interrupt word. Otherwise the next bits pick the channel and the two low bits pick the register: 0 is pause, 1 is configuration, 2 is interrupt control, and 3 is reserved.

Top module: `dma_chn_ctrl`

## Requirements
- R1: After reset, and again after any later reset, every enable, status flag, pause request, acknowledge, channel enable and interrupt line is 0.
- R2: In the interrupt control word, bits 0..4 are read/write enables for the events in this order: fragment, block, transaction, list, configuration error. Bits 16..20 read the status flags in the same order.
- R3: An event pulse (channel c, event k on evt_in[c*5+k]) sets status flag k one edge later only if enable k was already 1 before that edge. A pulse whose enable is 0 leaves the flag at 0.
- R4: A write of 1 to bit 24+k of the interrupt control word clears status flag k. Writing 0 there leaves the flag unchanged. Bits 24..28 read as 0.
- R5: If an event sets a flag in the same cycle that a write clears it, the flag stays set.
- R6: ch_irq[c] is 1 exactly when some status flag of channel c is set and its enable is 1. Clearing an enable drops the line but keeps the flag.
- R7: The global word (address top bit 1) reads bit c as ch_irq[c].
- R8: Bit 0 of the configuration register is the channel enable. It drives ch_enable[c], and the other bits of the register read as 0.
- R9: Bit 0 of the pause register is the request and drives ch_pause_req[c]. Bit 2 is the acknowledge. It rises at the second edge after the write of the request at the earliest, at an edge where xfer_idle[c] is 1, and stays high while the request stays set.
- R10: After the write that clears the request, the acknowledge drops at the following edge.
- R11: A register write or an event for one channel changes no state of any other channel, and writes to the reserved select change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | CH_W+3 | Register address {global, channel, select} |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| evt_in | input | NUM_CH*5 | Event pulses; channel c event k at bit c*5+k |
| xfer_idle | input | NUM_CH | Engine stopped at a transfer boundary, per channel |
| ch_enable | output | NUM_CH | Channel enable to the engine |
| ch_pause_req | output | NUM_CH | Pause request to the engine |
| ch_pause_ack | output | NUM_CH | Pause acknowledge |
| ch_irq | output | NUM_CH | Per-channel interrupt line |

## Verification
A wrong enable or status flag appears on the next read of the interrupt control word. It also shows on ch_irq and in the global word one edge after the event that should or should not have set it. Slips in pause timing are exposed one edge after the fault, because the acknowledge is read at every edge around a request, a change of idle and a release. Cross-channel corruption is caught by reading neighbouring channels after each activity on another channel.

// File: rtl/dma_ctl_pkg.sv
`timescale 1ns/1ps
package dma_ctl_pkg;
  localparam int EVT_N         = 5;
  localparam int EN_LSB        = 0;
  localparam int STS_LSB       = 16;
  localparam int CLR_LSB       = 24;
  localparam int PAUSE_REQ_BIT = 0;
  localparam int PAUSE_ACK_BIT = 2;
  localparam int CHEN_BIT      = 0;

  typedef enum logic [1:0] {
    RSEL_PAUSE = 2'd0,
    RSEL_CFG   = 2'd1,
    RSEL_INTC  = 2'd2,
    RSEL_RSVD  = 2'd3
  } rsel_e;
endpackage

// File: rtl/dma_evt_status.sv
`timescale 1ns/1ps
module dma_evt_status
  import dma_ctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_intc,
  input  logic [DATA_W-1:0] wdata,
  input  logic [EVT_N-1:0]  evt,
  output logic [EVT_N-1:0]  en_o,
  output logic [EVT_N-1:0]  sts_o,
  output logic              irq_o
);
  logic [EVT_N-1:0] en_q, sts_q, ev_set, clr;

  assign ev_set = evt & en_q;
  assign clr    = wr_intc ? wdata[CLR_LSB +: EVT_N] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sts_q <= '0;
    end else begin
      if (wr_intc) en_q <= wdata[EN_LSB +: EVT_N];
      sts_q <= (sts_q & ~clr) | ev_set;
    end
  end

  assign en_o  = en_q;
  assign sts_o = sts_q;
  assign irq_o = |(sts_q & en_q);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set != '0) |=> ((sts_q & $past(ev_set)) == $past(ev_set))); // R5
  AST_NO_STRAY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(ev_set)) == '0)); // R3
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((sts_q & $past(clr & ~ev_set)) == '0)); // R4
endmodule

// File: rtl/dma_pause_ctl.sv
`timescale 1ns/1ps
module dma_pause_ctl
  import dma_ctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pause,
  input  logic              wr_cfg,
  input  logic [DATA_W-1:0] wdata,
  input  logic              idle,
  output logic              req_o,
  output logic              ack_o,
  output logic              chen_o
);
  logic req_q, ack_q, chen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      ack_q  <= 1'b0;
      chen_q <= 1'b0;
    end else begin
      if (wr_pause) req_q  <= wdata[PAUSE_REQ_BIT];
      if (wr_cfg)   chen_q <= wdata[CHEN_BIT];
      ack_q <= req_q & (ack_q | idle);
    end
  end

  assign req_o  = req_q;
  assign ack_o  = ack_q;
  assign chen_o = chen_q;

  AST_ACK_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> ($past(req_q) && $past(idle))); // R9
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q |=> !ack_q); // R10
endmodule

// File: rtl/dma_chn_ctrl.sv
`timescale 1ns/1ps
module dma_chn_ctrl
  import dma_ctl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int AW    = CH_W + 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [AW-1:0]           reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  input  logic [NUM_CH*EVT_N-1:0] evt_in,
  input  logic [NUM_CH-1:0]       xfer_idle,
  output logic [NUM_CH-1:0]       ch_enable,
  output logic [NUM_CH-1:0]       ch_pause_req,
  output logic [NUM_CH-1:0]       ch_pause_ack,
  output logic [NUM_CH-1:0]       ch_irq
);
  logic            is_glb;
  logic [CH_W-1:0] ch_sel;
  rsel_e           rsel;
  logic [EVT_N-1:0] en_a  [NUM_CH];
  logic [EVT_N-1:0] sts_a [NUM_CH];

  assign is_glb = reg_addr[AW-1];
  assign ch_sel = reg_addr[CH_W+1:2];
  assign rsel   = rsel_e'(reg_addr[1:0]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = reg_we && !is_glb && (ch_sel == CH_W'(c));

    dma_evt_status #(.DATA_W(DATA_W)) u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_intc (hit && (rsel == RSEL_INTC)),
      .wdata   (reg_wdata),
      .evt     (evt_in[c*EVT_N +: EVT_N]),
      .en_o    (en_a[c]),
      .sts_o   (sts_a[c]),
      .irq_o   (ch_irq[c])
    );

    dma_pause_ctl #(.DATA_W(DATA_W)) u_pause (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_pause (hit && (rsel == RSEL_PAUSE)),
      .wr_cfg   (hit && (rsel == RSEL_CFG)),
      .wdata    (reg_wdata),
      .idle     (xfer_idle[c]),
      .req_o    (ch_pause_req[c]),
      .ack_o    (ch_pause_ack[c]),
      .chen_o   (ch_enable[c])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (is_glb) begin
      reg_rdata[NUM_CH-1:0] = ch_irq;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (ch_sel == CH_W'(c)) begin
          case (rsel)
            RSEL_PAUSE: begin
              reg_rdata[PAUSE_REQ_BIT] = ch_pause_req[c];
              reg_rdata[PAUSE_ACK_BIT] = ch_pause_ack[c];
            end
            RSEL_CFG:  reg_rdata[CHEN_BIT] = ch_enable[c];
            RSEL_INTC: begin
              reg_rdata[EN_LSB +: EVT_N]  = en_a[c];
              reg_rdata[STS_LSB +: EVT_N] = sts_a[c];
            end
            default: reg_rdata = '0;
          endcase
        end
      end
    end
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_irq[0]) |-> ($past(evt_in[EVT_N-1:0]) != '0) || $past(reg_we)); // R6
endmodule

// File: tb/dma_chn_ctrl_test.sv
`timescale 1ns/1ps
module dma_chn_ctrl_test;
  localparam int NCH = 4;
  localparam int AW  = 5;
  localparam int EW  = NCH * 5;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [31:0]   wdata;
    logic [EW-1:0] evt;
    logic [NCH-1:0] idle;
    logic [AW-1:0] raddr;
    logic [31:0]   exp;
    logic [3:0]    rq;
  } vec_t;

  localparam int NV = 23;
  // addresses: pause c*4, cfg c*4+1, intc c*4+2, reserved c*4+3, global 16
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'd2,  32'h0000_0011, 20'h0,     4'h0, 5'd2,  32'h0000_0011, 4'd2},  // R2
    '{1'b0, 5'd0,  32'h0,         20'h00003, 4'h0, 5'd2,  32'h0001_0011, 4'd3},  // R3
    '{1'b0, 5'd0,  32'h0,         20'h0,     4'h0, 5'd16, 32'h0000_0001, 4'd7},  // R7
    '{1'b1, 5'd2,  32'h0100_0011, 20'h00010, 4'h0, 5'd2,  32'h0010_0011, 4'd4},  // R4
    '{1'b1, 5'd2,  32'h1000_0011, 20'h00010, 4'h0, 5'd2,  32'h0010_0011, 4'd5},  // R5
    '{1'b1, 5'd2,  32'h0000_0001, 20'h0,     4'h0, 5'd16, 32'h0000_0000, 4'd6},  // R6
    '{1'b0, 5'd0,  32'h0,         20'h0,     4'h0, 5'd2,  32'h0010_0001, 4'd6},  // R6
    '{1'b1, 5'd6,  32'h0000_001F, 20'h00180, 4'h0, 5'd6,  32'h0000_001F, 4'd3},  // R3
    '{1'b0, 5'd0,  32'h0,         20'h00180, 4'h0, 5'd6,  32'h000C_001F, 4'd3},  // R3
    '{1'b0, 5'd0,  32'h0,         20'h0,     4'h0, 5'd2,  32'h0010_0001, 4'd11}, // R11
    '{1'b0, 5'd0,  32'h0,         20'h0,     4'h0, 5'd16, 32'h0000_0002, 4'd7},  // R7
    '{1'b1, 5'd6,  32'h1F00_001F, 20'h0,     4'h0, 5'd6,  32'h0000_001F, 4'd4},  // R4
    '{1'b1, 5'd9,  32'h0000_0001, 20'h0,     4'h0, 5'd9,  32'h0000_0001, 4'd8},  // R8
    '{1'b1, 5'd8,  32'h0000_0001, 20'h0,     4'h0, 5'd8,  32'h0000_0001, 4'd9},  // R9
    '{1'b0, 5'd0,  32'h0,         20'h0,     4'h4, 5'd8,  32'h0000_0005, 4'd9},  // R9
    '{1'b0, 5'd0,  32'h0,         20'h0,     4'h0, 5'd8,  32'h0000_0005, 4'd9},  // R9
    '{1'b1, 5'd8,  32'h0000_0000, 20'h0,     4'h0, 5'd8,  32'h0000_0004, 4'd10}, // R10
    '{1'b0, 5'd0,  32'h0,         20'h0,     4'h0, 5'd8,  32'h0000_0000, 4'd10}, // R10
    '{1'b1, 5'd12, 32'h0000_0001, 20'h0,     4'h8, 5'd12, 32'h0000_0001, 4'd9},  // R9
    '{1'b0, 5'd0,  32'h0,         20'h0,     4'h8, 5'd12, 32'h0000_0005, 4'd9},  // R9
    '{1'b1, 5'd3,  32'hFFFF_FFFF, 20'h0,     4'h8, 5'd3,  32'h0000_0000, 4'd11}, // R11
    '{1'b0, 5'd0,  32'h0,         20'h0,     4'h8, 5'd2,  32'h0010_0001, 4'd11}, // R11
    '{1'b1, 5'd1,  32'hFFFF_FFFE, 20'h0,     4'h8, 5'd1,  32'h0000_0000, 4'd8}   // R8
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_we = 1'b0;
  logic [AW-1:0]  reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_rdata;
  logic [EW-1:0]  evt_in = '0;
  logic [NCH-1:0] xfer_idle = '0;
  logic [NCH-1:0] ch_enable, ch_pause_req, ch_pause_ack, ch_irq;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dma_chn_ctrl #(.NUM_CH(NCH), .DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .xfer_idle(xfer_idle), .ch_enable(ch_enable), .ch_pause_req(ch_pause_req),
    .ch_pause_ack(ch_pause_ack), .ch_irq(ch_irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag, input logic [31:0] exp);
    reg_addr = a;
    #0.5;
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #11 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    rd(5'd2, "R1 intc", 32'h0);
    rd(5'd0, "R1 pause", 32'h0);
    rd(5'd1, "R1 cfg", 32'h0);
    rd(5'd16, "R1 global", 32'h0);
    check("R1 pins", {16'h0, ch_enable, ch_pause_req, ch_pause_ack, ch_irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      reg_we    = VEC[i].we;
      reg_addr  = VEC[i].addr;
      reg_wdata = VEC[i].wdata;
      evt_in    = VEC[i].evt;
      xfer_idle = VEC[i].idle;
      @(posedge clk); #1;
      reg_we = 1'b0;
      evt_in = '0;
      rd(VEC[i].raddr, $sformatf("R%0d vector %0d", VEC[i].rq, i), VEC[i].exp);
    end

    // pin-level state after the table: R8 R9 R6
    check("R8 ch_enable", {28'h0, ch_enable}, 32'h4);
    check("R9 ch_pause_req", {28'h0, ch_pause_req}, 32'h8);
    check("R9 ch_pause_ack", {28'h0, ch_pause_ack}, 32'h8);
    check("R6 ch_irq idle", {28'h0, ch_irq}, 32'h0);

    // R6: block event on channel 1 raises its line one edge later
    evt_in = 20'h00040;
    @(posedge clk); #1;
    evt_in = '0;
    check("R6 ch_irq after event", {28'h0, ch_irq}, 32'h2);

    // R1: reset in mid-run returns everything to zero
    rst_n = 1'b0;
    #3;
    check("R1 pins after reset", {16'h0, ch_enable, ch_pause_req, ch_pause_ack, ch_irq}, 32'h0);
    rd(5'd6, "R1 intc ch1 after reset", 32'h0);
    rd(5'd12, "R1 pause ch3 after reset", 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule